// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of frame bytes into a serial HDLC line signal, one line bit per clock. While there is nothing to send, the line carries back-to-back flag octets. A frame can begin only when a flag has been fully sent. The block then sends the bytes it is given without reading them: address, control and any information octets are passed through as they are. After the byte marked as last, it appends a frame check sequence and then a closing flag. That closing flag can also serve as the opening flag of the next frame.

The check sequence can be chosen per frame from three CRCs. Two of them give a 16-bit field and one gives a 32-bit field. Between the first address bit and the last check bit, a zero is inserted after every run of five ones, so that no run of six ones can appear outside a flag. Bytes come in through a valid/ready handshake with a last marker. If the source fails to offer a byte in time, the frame is closed early instead of being corrupted.

Top module: `hdlc_tx`

## Requirements
- R1: During reset, `line_bit` and `tx_ready` are 0. With no byte offered, the line carries repeated flags 0x7E, sent LSB first as the bit pattern 0,1,1,1,1,1,1,0.
- R2: A byte is taken on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only in the cycle that sends the last bit of a flag or of a data byte, and only while no stuffed zero is being sent. A frame starts only after a complete flag.
- R3: Each taken byte is sent unaltered and LSB first, starting in the cycle after the last bit of the preceding flag or byte (plus any inserted zero). Its contents are not interpreted.
- R4: After a byte taken with `tx_last` high, no further byte is taken until the closing flag has ended. The check sequence follows that byte, and then one closing flag.
- R5: `fcs_sel` encodings: 0 selects CRC-CCITT (reflected polynomial 0x8408), 1 selects CRC-16 (reflected 0xA001), 2 selects CRC-32 (reflected 0xEDB88320), and 3 behaves as 0. The register is preset to all ones and runs over every frame bit before the check field. The complement is sent low bit first, as 16 bits for codes 0, 1 and 3 and as 32 bits for code 2.
- R6: `fcs_sel` is sampled when the first byte of a frame is taken. Changes to it during the frame have no effect on that frame's check field.
- R7: After five consecutive ones inside the span from the first frame byte to the last check bit, a 0 is inserted before the next bit, even when that next bit belongs to the closing flag. The inserted 0 restarts the count, and flag bits are never stuffed.
- R8: If `tx_valid` is low at a byte boundary inside a frame whose last byte has not yet been taken, the frame ends there. The check sequence covers the bytes taken so far and is followed by the closing flag.
- R9: A byte offered while a closing flag is being sent is taken at the end of that flag, so one flag separates back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fcs_sel | input | 2 | Check sequence choice, sampled at frame start |
| tx_data | input | 8 | Frame byte offered |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_last | input | 1 | Offered byte is the final byte of the frame |
| tx_ready | output | 1 | Block takes the offered byte on this clock edge |
| line_bit | output | 1 | Serial HDLC line output |

## Verification
A behavioural model builds the expected line bits and compares them with the output on every cycle, covering idle flags, handshakes and frames. The frames are chosen to separate the different behaviours:
- Mixed bytes under each of the three CRCs, plus code 3, show whether the right polynomial, length and bit order are used.
- Frames of all-ones bytes and of bytes equal to the flag value exercise stuffing inside data, across the boundary into the check field, and just before the closing flag.
- Changing the CRC selection in mid-frame, back-to-back frames, and a source that stops offering bytes without a last marker check the frame-start sampling, flag sharing and early close.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 32;
    localparam int STUFF_RUN = 5;
    localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;

    typedef enum logic [1:0] {
        FCS_CCITT = 2'd0,
        FCS_CRC16 = 2'd1,
        FCS_CRC32 = 2'd2
    } fcs_kind_e;

    typedef enum logic [1:0] {
        ST_FLAG,
        ST_DATA,
        ST_FCS
    } tx_state_e;

    typedef struct packed {
        logic bit_val;
        logic stuffable;
    } line_sym_t;

    function automatic fcs_kind_e decode_kind(input logic [1:0] sel);
        if (sel == 2'd3) return FCS_CCITT;
        return fcs_kind_e'(sel);
    endfunction

    function automatic logic [CRC_W-1:0] crc_poly(input fcs_kind_e k);
        case (k)
            FCS_CRC16: return 32'h0000_A001;
            FCS_CRC32: return 32'hEDB8_8320;
            default:   return 32'h0000_8408;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] crc_preset(input fcs_kind_e k);
        return (k == FCS_CRC32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic int fcs_bits(input fcs_kind_e k);
        return (k == FCS_CRC32) ? 32 : 16;
    endfunction

    // One LSB-first shift of a reflected CRC register.
    function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] crc,
                                                      input logic din,
                                                      input fcs_kind_e k);
        logic [CRC_W-1:0] nx;
        nx = crc >> 1;
        if (crc[0] ^ din) nx = nx ^ crc_poly(k);
        return nx;
    endfunction
endpackage

// File: rtl/hdlc_crc.sv
`timescale 1ns/1ps
module hdlc_crc
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  fcs_kind_e        init_kind,
    input  logic             step,
    input  logic             din,
    input  fcs_kind_e        kind,
    output logic [CRC_W-1:0] crc_nx
);
    logic [CRC_W-1:0] crc_q;

    assign crc_nx = crc_bit_step(crc_q, din, kind);

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= '1;
        else if (init) crc_q <= crc_preset(init_kind);
        else if (step) crc_q <= crc_nx;
    end
endmodule

// File: rtl/hdlc_zero_ins.sv
`timescale 1ns/1ps
module hdlc_zero_ins
    import hdlc_tx_pkg::*;
#(
    parameter int RUN = STUFF_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  line_sym_t sym,
    output logic      stall,
    output logic      line_bit
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones_q;

    assign stall = (ones_q == CW'(RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q   <= '0;
            line_bit <= 1'b0;
        end else if (stall) begin
            line_bit <= 1'b0;
            ones_q   <= '0;
        end else begin
            line_bit <= sym.bit_val;
            if (sym.stuffable && sym.bit_val) ones_q <= ones_q + 1'b1;
            else                              ones_q <= '0;
        end
    end
endmodule

// File: rtl/hdlc_framer.sv
`timescale 1ns/1ps
module hdlc_framer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [1:0]        fcs_sel,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    output line_sym_t         sym,
    output logic              crc_init,
    output fcs_kind_e         crc_init_kind,
    output logic              crc_step,
    output logic              crc_din,
    output fcs_kind_e         crc_kind,
    input  logic [CRC_W-1:0]  crc_nx
);
    localparam int IDX_W = $clog2(CRC_W);

    tx_state_e         state_q;
    logic [CRC_W-1:0]  sh_q;
    logic [IDX_W-1:0]  bidx_q;
    logic              last_q;
    fcs_kind_e         kind_q;
    logic              byte_end;
    logic              fcs_end;
    logic              take;

    assign byte_end = (bidx_q == IDX_W'(BYTE_W - 1));
    assign fcs_end  = (bidx_q == IDX_W'(fcs_bits(kind_q) - 1));
    assign tx_ready = advance && byte_end &&
                      ((state_q == ST_FLAG) || ((state_q == ST_DATA) && !last_q));
    assign take     = tx_ready && tx_valid;

    assign sym.bit_val   = sh_q[0];
    assign sym.stuffable = (state_q != ST_FLAG);

    assign crc_init      = take && (state_q == ST_FLAG);
    assign crc_init_kind = decode_kind(fcs_sel);
    assign crc_step      = advance && (state_q == ST_DATA);
    assign crc_din       = sh_q[0];
    assign crc_kind      = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLAG;
            sh_q    <= {{(CRC_W-BYTE_W){1'b0}}, FLAG_OCTET};
            bidx_q  <= '0;
            last_q  <= 1'b0;
            kind_q  <= FCS_CCITT;
        end else if (advance) begin
            bidx_q <= bidx_q + 1'b1;
            sh_q   <= sh_q >> 1;
            case (state_q)
                ST_FLAG: begin
                    if (byte_end) begin
                        bidx_q <= '0;
                        if (take) begin
                            state_q <= ST_DATA;
                            sh_q    <= {{(CRC_W-BYTE_W){1'b0}}, tx_data};
                            last_q  <= tx_last;
                            kind_q  <= decode_kind(fcs_sel);
                        end else begin
                            sh_q <= {{(CRC_W-BYTE_W){1'b0}}, FLAG_OCTET};
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_end) begin
                        bidx_q <= '0;
                        if (take) begin
                            sh_q   <= {{(CRC_W-BYTE_W){1'b0}}, tx_data};
                            last_q <= tx_last;
                        end else begin
                            state_q <= ST_FCS;
                            sh_q    <= ~crc_nx;
                        end
                    end
                end
                default: begin
                    if (fcs_end) begin
                        bidx_q  <= '0;
                        state_q <= ST_FLAG;
                        sh_q    <= {{(CRC_W-BYTE_W){1'b0}}, FLAG_OCTET};
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hdlc_tx.sv
`timescale 1ns/1ps
module hdlc_tx
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fcs_sel,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              line_bit
);
    line_sym_t        sym;
    logic             stall;
    logic             crc_init;
    fcs_kind_e        crc_init_kind;
    logic             crc_step;
    logic             crc_din;
    fcs_kind_e        crc_kind;
    logic [CRC_W-1:0] crc_nx;

    hdlc_framer u_framer (
        .clk           (clk),
        .rst           (rst),
        .advance       (!stall),
        .fcs_sel       (fcs_sel),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_last       (tx_last),
        .tx_ready      (tx_ready),
        .sym           (sym),
        .crc_init      (crc_init),
        .crc_init_kind (crc_init_kind),
        .crc_step      (crc_step),
        .crc_din       (crc_din),
        .crc_kind      (crc_kind),
        .crc_nx        (crc_nx)
    );

    hdlc_crc u_crc (
        .clk       (clk),
        .rst       (rst),
        .init      (crc_init),
        .init_kind (crc_init_kind),
        .step      (crc_step),
        .din       (crc_din),
        .kind      (crc_kind),
        .crc_nx    (crc_nx)
    );

    hdlc_zero_ins #(.RUN(STUFF_RUN)) u_zins (
        .clk      (clk),
        .rst      (rst),
        .sym      (sym),
        .stall    (stall),
        .line_bit (line_bit)
    );
endmodule

// File: rtl/hdlc_tx_checker.sv
`timescale 1ns/1ps
module hdlc_tx_checker (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_last,
    input logic line_bit,
    input logic stall
);
    logic [2:0] run_q;
    logic [3:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 3'd0;
            gap_q <= 4'hF;
        end else begin
            run_q <= line_bit ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
            gap_q <= tx_ready ? 4'd0 : ((gap_q == 4'hF) ? gap_q : gap_q + 4'd1);
        end
    end

    AST_RUN_AT_MOST_SIX: assert property (@(posedge clk) disable iff (rst) run_q <= 3'd6); // R7
    AST_STUFFED_BIT_ZERO: assert property (@(posedge clk) disable iff (rst) stall |=> !line_bit); // R7
    AST_READY_NOT_IN_STUFF: assert property (@(posedge clk) disable iff (rst) tx_ready |-> !stall); // R2
    AST_READY_BYTE_SPACING: assert property (@(posedge clk) disable iff (rst) tx_ready |-> (gap_q >= 4'd7)); // R2
    AST_LAST_STOPS_TAKING: assert property (@(posedge clk) disable iff (rst) (tx_valid && tx_ready && tx_last) |=> !tx_ready); // R4
endmodule

bind hdlc_tx hdlc_tx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .line_bit (line_bit),
    .stall    (stall)
);

// File: tb/hdlc_tx_bench.sv
`timescale 1ns/1ps
module hdlc_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] fcs_sel = 2'd0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_valid = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic       line_bit;

    always #2 clk = ~clk;

    hdlc_tx u_hdlc_tx (
        .clk(clk), .rst(rst), .fcs_sel(fcs_sel), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready), .line_bit(line_bit)
    );

    int n_tests = 0;
    int n_fail  = 0;

    bit    exp_q[$];
    string tag_q[$];

    logic [7:0] fr_bytes[$];
    int fr_n = 0, fr_idx = 0, fr_sel = 0, fr_sel_late = 0, takes = 0;
    bit fr_active = 0, use_last = 1, acc_pend = 0, started = 0, done = 0;

    function automatic logic [31:0] ref_fcs(input logic [7:0] d[$], input int sel);
        logic [31:0] poly, crc;
        bit wide;
        wide = (sel == 2);
        poly = (sel == 1) ? 32'h0000A001 : (wide ? 32'hEDB88320 : 32'h00008408);
        crc  = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
        foreach (d[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb  = crc[0] ^ d[i][b];
                crc = crc >> 1;
                if (fb) crc = crc ^ poly;
            end
        end
        crc = ~crc;
        if (!wide) crc[31:16] = 16'h0;
        return crc;
    endfunction

    task automatic push_flag();
        for (int b = 0; b < 8; b++) begin
            exp_q.push_back(b != 0 && b != 7);
            tag_q.push_back("R1 flag");
        end
    endtask

    task automatic push_frame();
        bit    raw[$];
        string rtag[$];
        logic [31:0] fcs;
        int len, ones;
        for (int i = 0; i < fr_n; i++)
            for (int b = 0; b < 8; b++) begin
                raw.push_back(fr_bytes[i][b]);
                rtag.push_back("R3 data");
            end
        fcs = ref_fcs(fr_bytes, fr_sel);
        len = (fr_sel == 2) ? 32 : 16;
        for (int b = 0; b < len; b++) begin
            raw.push_back(fcs[b]);
            rtag.push_back("R5 fcs");
        end
        ones = 0;
        foreach (raw[i]) begin
            if (ones == 5) begin
                exp_q.push_back(1'b0);
                tag_q.push_back("R7 stuffed");
                ones = 0;
            end
            exp_q.push_back(raw[i]);
            tag_q.push_back(rtag[i]);
            ones = raw[i] ? ones + 1 : 0;
        end
        if (ones == 5) begin
            exp_q.push_back(1'b0);
            tag_q.push_back("R7 stuffed");
        end
        push_flag();
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Model and driver, all on the falling edge.
    initial begin
        push_flag();
        forever begin
            @(negedge clk);
            if (rst) begin
                chk(line_bit == 1'b0, "R1 line_bit in reset", int'(line_bit), 0);
                chk(tx_ready == 1'b0, "R1 tx_ready in reset", int'(tx_ready), 0);
            end else if (!started) begin
                started = 1;
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(line_bit == e, {t, " line bit"}, int'(line_bit), int'(e));
                if (exp_q.size() == 0) begin
                    if (tx_valid) push_frame();
                    else          push_flag();
                end
            end
            if (acc_pend) begin
                takes++;
                fr_idx++;
            end
            if (fr_active && fr_idx < fr_n) begin
                tx_valid = 1'b1;
                tx_data  = fr_bytes[fr_idx];
                tx_last  = use_last && (fr_idx == fr_n - 1);
                fcs_sel  = (fr_idx == 0) ? 2'(fr_sel_raw(fr_sel)) : 2'(fr_sel_late);
            end else begin
                fr_active = 0;
                tx_valid  = 1'b0;
                tx_data   = 8'd0;
                tx_last   = 1'b0;
            end
            acc_pend = tx_valid && tx_ready;
        end
    end

    int sel_code = 0;
    function automatic int fr_sel_raw(input int s);
        return sel_code;
    endfunction

    task automatic send(input logic [7:0] b[$], input int code, input int late, input bit last);
        @(posedge clk);
        #1;
        fr_bytes    = b;
        fr_n        = b.size();
        sel_code    = code;
        fr_sel      = (code == 3) ? 0 : code;
        fr_sel_late = late;
        use_last    = last;
        fr_idx      = 0;
        takes       = 0;
        fr_active   = 1;
        wait (!fr_active);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [7:0] dig[$];
        dig = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        // Bench CRC reference against published check values (R5)
        chk(ref_fcs(dig, 0) == 32'h906E, "R5 ccitt check value", ref_fcs(dig, 0), 32'h906E);
        chk(ref_fcs(dig, 1) == 32'hB4C8, "R5 crc16 check value", ref_fcs(dig, 1), 32'hB4C8);
        chk(ref_fcs(dig, 2) == 32'hCBF43926, "R5 crc32 check value", ref_fcs(dig, 2), 32'hCBF43926);

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        settle(40);                                   // R1 idle flags

        send('{8'h03, 8'h3F, 8'h12, 8'hA5}, 0, 0, 1);  // R3 R5 CCITT
        chk(takes == 4, "R2 bytes taken frame A", takes, 4);
        settle(120);

        send('{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1, 1, 1);  // R7 heavy stuffing, CRC-16
        chk(takes == 4, "R4 bytes taken frame B", takes, 4);
        settle(120);

        send('{8'h7E, 8'h7E, 8'h55, 8'h00, 8'hF8}, 2, 2, 1); // R5 CRC-32, flag-like data
        chk(takes == 5, "R3 bytes taken frame C", takes, 5);
        settle(140);

        send('{8'hC1, 8'h1F, 8'hE0}, 3, 3, 1);        // R5 code 3 as CCITT
        chk(takes == 3, "R5 bytes taken frame D", takes, 3);
        settle(120);

        send('{8'h01, 8'h10, 8'hAA, 8'h0F}, 2, 0, 1);  // R6 selection changed mid-frame
        chk(takes == 4, "R6 bytes taken frame E", takes, 4);
        settle(140);

        send('{8'hF0, 8'h13}, 0, 0, 1);               // R9 back-to-back pair
        chk(takes == 2, "R9 bytes taken frame F", takes, 2);
        send('{8'h7F, 8'hFE, 8'h5A}, 1, 1, 1);
        chk(takes == 3, "R9 bytes taken frame G", takes, 3);
        settle(120);

        send('{8'h44, 8'h03, 8'h99}, 0, 0, 0);        // R8 source stops without last
        chk(takes == 3, "R8 bytes taken before early close", takes, 3);
        settle(120);

        send('{8'hFF, 8'h03}, 2, 2, 1);               // R4 minimal frame
        chk(takes == 2, "R4 bytes taken minimal frame", takes, 2);
        settle(150);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule